// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block recovers characters from an asynchronous serial line. It samples the incoming line against a tick that runs at sixteen times the bit rate. It confirms a start bit at its middle, then collects a 7-bit or 8-bit character least significant bit first. After the character it may take a parity slot, and it always takes exactly one stop bit. At the end of each character it publishes the data together with parity, framing and overrun flags, and raises one of two one-cycle events.

A routing bit in the mode inputs chooses how a character that arrived with an error is announced. With routing 0, the error event carries it alone. With routing 1, the normal completion event carries it alone. The receiver runs only while both the power enable and the receive enable are high. The receive enable passes through a synchronizer. A disable that lasts only one base clock leaves a reception in progress untouched. A longer disable throws the partial character away.

Top module: `serial_rx_unit`

## Requirements
- R1: After reset, `rx_data` is zero, all three error flags are low and neither event output is high.
- R2: With `len8`=1, eight data bits are taken least significant bit first, each sampled at the middle of its bit. A clean character raises `rx_done` for one cycle and clears all error flags.
- R3: With `len8`=0, seven data bits are taken, and `rx_data[7]` reads 0.
- R4: `par_sel` encodings: 2'b00 has no parity slot, 2'b10 checks odd parity and 2'b11 checks even parity. A check sets `err_parity` when the ones count of the data plus the parity bit has the wrong oddness, and clears it otherwise.
- R5: With `par_sel`=2'b01 a parity slot is taken but its value is ignored. `err_parity` stays low and no error event results from that slot.
- R6: Only one stop bit is checked. A start bit that follows directly after a single stop bit begins the next character.
- R7: A low stop bit sets `err_frame`. The receiver then waits for the line to go high before it looks for another start bit.
- R8: A character that completes while the previous one has not been acknowledged with `rd_ack` sets `err_overrun`. An `rd_ack` pulse acknowledges the character held.
- R9: A character with any error raises only `rx_err` when `err_route`=0, and only `rx_done` when `err_route`=1. The two events are never high together.
- R10: A low line is confirmed as a start bit at the eighth tick after it is detected. If the line is high there, the start is dropped without any event.
- R11: If the line is already low when reception becomes enabled, that low is taken as a start bit.
- R12: The receive enable is synchronized to the base clock. A drop of one base clock leaves a reception in progress intact. A drop of two or more base clocks returns the receiver to idle and discards the partial character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| pwr_en | input | 1 | Power enable of the receiver |
| rx_en | input | 1 | Receive enable, asynchronous to the receiver state |
| rxd | input | 1 | Serial input line, idle high |
| par_sel | input | 2 | Parity mode: 00 none, 01 unchecked slot, 10 odd, 11 even |
| len8 | input | 1 | 1 selects 8 data bits, 0 selects 7 |
| err_route | input | 1 | 0 sends errored characters to `rx_err`, 1 sends them to `rx_done` |
| rd_ack | input | 1 | One-cycle pulse acknowledging the held character |
| rx_data | output | 8 | Last received character |
| err_parity | output | 1 | Parity error of the last character |
| err_frame | output | 1 | Stop bit of the last character was low |
| err_overrun | output | 1 | Last character completed while its predecessor was unacknowledged |
| rx_done | output | 1 | Normal completion event, one cycle |
| rx_err | output | 1 | Error completion event, one cycle |

## Verification
The assertions assume that `par_sel`, `len8` and `err_route` hold steady from the start bit to the completion event. They also assume that `baud_tick` is a single-cycle pulse, so the value sampled at completion is the value that decides parity handling and routing. The stimulus changes mode inputs only while the line is idle and no character is in flight. It drives one tick every four base clocks and holds each bit for sixty-four base clocks, which puts every sample close to the middle of its bit. Enable drops are placed at chosen base-clock edges, so both the one-cycle and the long-drop cases are reached on purpose.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_ZERO = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_EVEN = 2'b11
  } par_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP,
    ST_WAIT_HI
  } rx_state_e;

endpackage

// File: rtl/rx_input_sync.sv
module rx_input_sync #(
  parameter int STAGES      = 2,
  parameter int REINIT_CLKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rxd,
  input  logic en_raw,
  output logic rxd_s,
  output logic en_s,
  output logic reinit
);

  localparam int CW = $clog2(REINIT_CLKS + 1);

  logic [STAGES-1:0] rxd_chain;
  logic [STAGES-1:0] en_chain;
  logic [CW-1:0]     low_q;
  logic [CW-1:0]     low_d;

  // synchronizer stages; the line resets to its idle level
  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            rxd_chain[0] <= 1'b1;
            en_chain[0]  <= 1'b0;
          end else begin
            rxd_chain[0] <= rxd;
            en_chain[0]  <= en_raw;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            rxd_chain[g] <= 1'b1;
            en_chain[g]  <= 1'b0;
          end else begin
            rxd_chain[g] <= rxd_chain[g-1];
            en_chain[g]  <= en_chain[g-1];
          end
        end
      end
    end
  endgenerate

  assign rxd_s = rxd_chain[STAGES-1];
  assign en_s  = en_chain[STAGES-1];

  // consecutive low cycles of the synchronized enable, saturating
  always_comb begin
    low_d = low_q;
    if (en_s) begin
      low_d = '0;
    end else if (low_q != CW'(REINIT_CLKS)) begin
      low_d = low_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q <= CW'(REINIT_CLKS);
    end else begin
      low_q <= low_d;
    end
  end

  assign reinit = !en_s && (low_q >= CW'(REINIT_CLKS - 1));

  // R12: a reinitialisation needs at least two low cycles in a row
  a_r12_reinit_needs_two_low: assert property (@(posedge clk) disable iff (!rst_n)
    reinit |-> (!en_s && $past(!en_s)));

endmodule

// File: rtl/rx_bit_engine.sv
module rx_bit_engine
  import uart_rx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              reinit,
  input  logic              tick,
  input  logic              rxd_s,
  input  logic [1:0]        par_sel,
  input  logic              len8,
  output logic              strobe,
  output logic [DATA_W-1:0] data,
  output logic              par_bit,
  output logic              stop_bit
);

  localparam int TW   = $clog2(TICKS_PER_BIT);
  localparam int IW   = $clog2(DATA_W);
  localparam int HALF = TICKS_PER_BIT / 2;

  rx_state_e         state_q, state_d;
  logic [TW-1:0]     tick_q, tick_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              par_q, par_d;
  logic              stop_q, stop_d;
  logic              strobe_q, strobe_d;
  logic              bit_end;
  logic              mid_start;
  logic [IW-1:0]     last_idx;

  assign bit_end   = tick && (tick_q == TW'(TICKS_PER_BIT - 1));
  assign mid_start = tick && (tick_q == TW'(HALF - 1));
  assign last_idx  = len8 ? IW'(DATA_W - 1) : IW'(DATA_W - 2);

  always_comb begin
    state_d  = state_q;
    tick_d   = tick_q;
    idx_d    = idx_q;
    sh_d     = sh_q;
    par_d    = par_q;
    stop_d   = stop_q;
    strobe_d = 1'b0;
    if (reinit) begin
      state_d = ST_IDLE;
      tick_d  = '0;
      idx_d   = '0;
    end else if (run) begin
      unique case (state_q)
        ST_IDLE: begin
          tick_d = '0;
          idx_d  = '0;
          if (!rxd_s) state_d = ST_START;
        end
        ST_START: begin
          if (mid_start) begin
            tick_d  = '0;
            state_d = rxd_s ? ST_IDLE : ST_DATA;
          end else if (tick) begin
            tick_d = tick_q + 1'b1;
          end
        end
        ST_DATA: begin
          if (bit_end) begin
            tick_d = '0;
            sh_d   = {rxd_s, sh_q[DATA_W-1:1]};
            if (idx_q == last_idx) begin
              idx_d   = '0;
              state_d = (par_mode_e'(par_sel) == PAR_NONE) ? ST_STOP : ST_PARITY;
            end else begin
              idx_d = idx_q + 1'b1;
            end
          end else if (tick) begin
            tick_d = tick_q + 1'b1;
          end
        end
        ST_PARITY: begin
          if (bit_end) begin
            tick_d  = '0;
            par_d   = rxd_s;
            state_d = ST_STOP;
          end else if (tick) begin
            tick_d = tick_q + 1'b1;
          end
        end
        ST_STOP: begin
          if (bit_end) begin
            tick_d   = '0;
            stop_d   = rxd_s;
            strobe_d = 1'b1;
            state_d  = rxd_s ? ST_IDLE : ST_WAIT_HI;
          end else if (tick) begin
            tick_d = tick_q + 1'b1;
          end
        end
        ST_WAIT_HI: begin
          if (rxd_s) state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      tick_q   <= '0;
      idx_q    <= '0;
      sh_q     <= '0;
      par_q    <= 1'b0;
      stop_q   <= 1'b1;
      strobe_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      tick_q   <= tick_d;
      idx_q    <= idx_d;
      sh_q     <= sh_d;
      par_q    <= par_d;
      stop_q   <= stop_d;
      strobe_q <= strobe_d;
    end
  end

  assign strobe   = strobe_q;
  assign data     = len8 ? sh_q : {1'b0, sh_q[DATA_W-1:1]};
  assign par_bit  = par_q;
  assign stop_bit = stop_q;

  // R12: a long enable drop leaves the engine idle with no completion
  a_r12_reinit_idle: assert property (@(posedge clk) disable iff (!rst_n)
    reinit |=> (state_q == ST_IDLE && !strobe_q));

  // R6: every completion comes out of the single stop-bit slot
  a_r6_single_stop: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |-> ($past(state_q) == ST_STOP));

  // R10: a start candidate only turns into data after the mid-bit sample
  a_r10_start_to_data: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA && $past(state_q) == ST_START) |-> $past(mid_start && !rxd_s));

endmodule

// File: rtl/rx_result.sv
module rx_result
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [DATA_W-1:0] data,
  input  logic              par_bit,
  input  logic              stop_bit,
  input  logic [1:0]        par_sel,
  input  logic              err_route,
  input  logic              rd_ack,
  output logic [DATA_W-1:0] rx_data,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_overrun,
  output logic              done_pulse,
  output logic              err_pulse
);

  logic [DATA_W-1:0] data_q, data_d;
  logic              pe_q, pe_d, fe_q, fe_d, ov_q, ov_d;
  logic              unread_q, unread_d;
  logic              done_q, done_d, errp_q, errp_d;
  logic              odd_ones;
  logic              pe_now;
  logic              any_err;

  assign odd_ones = ^{data, par_bit};

  always_comb begin
    unique case (par_mode_e'(par_sel))
      PAR_ODD:  pe_now = !odd_ones;
      PAR_EVEN: pe_now = odd_ones;
      default:  pe_now = 1'b0;
    endcase
  end

  assign any_err = pe_now || !stop_bit || unread_q;

  always_comb begin
    data_d   = data_q;
    pe_d     = pe_q;
    fe_d     = fe_q;
    ov_d     = ov_q;
    unread_d = unread_q;
    done_d   = 1'b0;
    errp_d   = 1'b0;
    if (strobe) begin
      data_d   = data;
      pe_d     = pe_now;
      fe_d     = !stop_bit;
      ov_d     = unread_q;
      unread_d = 1'b1;
      if (any_err && !err_route) begin
        errp_d = 1'b1;
      end else begin
        done_d = 1'b1;
      end
    end else if (rd_ack) begin
      unread_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      pe_q     <= 1'b0;
      fe_q     <= 1'b0;
      ov_q     <= 1'b0;
      unread_q <= 1'b0;
      done_q   <= 1'b0;
      errp_q   <= 1'b0;
    end else begin
      data_q   <= data_d;
      pe_q     <= pe_d;
      fe_q     <= fe_d;
      ov_q     <= ov_d;
      unread_q <= unread_d;
      done_q   <= done_d;
      errp_q   <= errp_d;
    end
  end

  assign rx_data     = data_q;
  assign err_parity  = pe_q;
  assign err_frame   = fe_q;
  assign err_overrun = ov_q;
  assign done_pulse  = done_q;
  assign err_pulse   = errp_q;

  // R9: the two completion events never coincide
  a_r9_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_pulse && err_pulse));

  // R9: an error event only appears when routing selected it
  a_r9_route_err: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(!err_route));

  // R9: every event follows a completion strobe from the engine
  a_r9_event_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pulse || err_pulse) |-> $past(strobe));

  // R5: the unchecked parity mode never flags parity
  a_r5_zero_par_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && par_mode_e'(par_sel) == PAR_ZERO) |=> !err_parity);

endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit #(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16,
  parameter int SYNC_STAGES   = 2,
  parameter int REINIT_CLKS   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              pwr_en,
  input  logic              rx_en,
  input  logic              rxd,
  input  logic [1:0]        par_sel,
  input  logic              len8,
  input  logic              err_route,
  input  logic              rd_ack,
  output logic [DATA_W-1:0] rx_data,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_overrun,
  output logic              rx_done,
  output logic              rx_err
);

  logic              rxd_s;
  logic              en_s;
  logic              reinit;
  logic              strobe;
  logic [DATA_W-1:0] eng_data;
  logic              par_bit;
  logic              stop_bit;

  rx_input_sync #(
    .STAGES     (SYNC_STAGES),
    .REINIT_CLKS(REINIT_CLKS)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .rxd   (rxd),
    .en_raw(pwr_en && rx_en),
    .rxd_s (rxd_s),
    .en_s  (en_s),
    .reinit(reinit)
  );

  rx_bit_engine #(
    .DATA_W       (DATA_W),
    .TICKS_PER_BIT(TICKS_PER_BIT)
  ) u_engine (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (en_s),
    .reinit  (reinit),
    .tick    (baud_tick),
    .rxd_s   (rxd_s),
    .par_sel (par_sel),
    .len8    (len8),
    .strobe  (strobe),
    .data    (eng_data),
    .par_bit (par_bit),
    .stop_bit(stop_bit)
  );

  rx_result #(
    .DATA_W(DATA_W)
  ) u_result (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .data       (eng_data),
    .par_bit    (par_bit),
    .stop_bit   (stop_bit),
    .par_sel    (par_sel),
    .err_route  (err_route),
    .rd_ack     (rd_ack),
    .rx_data    (rx_data),
    .err_parity (err_parity),
    .err_frame  (err_frame),
    .err_overrun(err_overrun),
    .done_pulse (rx_done),
    .err_pulse  (rx_err)
  );

  // R12: no completion can come out while the receiver is held off
  a_r12_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reinit) |-> !strobe);

endmodule

// File: tb/serial_rx_unit_test.sv
module serial_rx_unit_test;

  localparam int BIT_CLKS = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       pwr_en = 1'b0;
  logic       rx_en = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] par_sel = 2'b00;
  logic       len8 = 1'b1;
  logic       err_route = 1'b0;
  logic       rd_ack = 1'b0;
  logic       auto_ack = 1'b1;
  logic [7:0] rx_data;
  logic       err_parity, err_frame, err_overrun, rx_done, rx_err;

  int checks = 0;
  int errors = 0;
  int n_done = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  serial_rx_unit uut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .pwr_en(pwr_en),
    .rx_en(rx_en), .rxd(rxd), .par_sel(par_sel), .len8(len8),
    .err_route(err_route), .rd_ack(rd_ack), .rx_data(rx_data),
    .err_parity(err_parity), .err_frame(err_frame),
    .err_overrun(err_overrun), .rx_done(rx_done), .rx_err(rx_err)
  );

  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      div = (div + 1) % 4;
      baud_tick = (div == 0);
    end
  end

  always @(posedge clk) begin
    if (rx_done) n_done <= n_done + 1;
    if (rx_err)  n_err  <= n_err + 1;
  end

  initial begin
    forever begin
      @(negedge clk);
      rd_ack = auto_ack && (rx_done || rx_err);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold_bit(input logic v);
    rxd = v;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input int nbits, input bit has_par,
                            input logic pbit, input logic stopv);
    hold_bit(1'b0);
    for (int i = 0; i < nbits; i++) hold_bit(d[i]);
    if (has_par) hold_bit(pbit);
    hold_bit(stopv);
    rxd = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic expect_char(input string req, input logic [7:0] d, input int dd,
                             input int de, input int d0, input int e0,
                             input bit pe, input bit fe, input bit ov);
    check(rx_data == d, req, rx_data, d);
    check(n_done - d0 == dd, {req, " done"}, n_done - d0, dd);
    check(n_err - e0 == de, {req, " err"}, n_err - e0, de);
    check(err_parity == pe, {req, " parity flag"}, err_parity, pe);
    check(err_frame == fe, {req, " frame flag"}, err_frame, fe);
    check(err_overrun == ov, {req, " overrun flag"}, err_overrun, ov);
  endtask

  task automatic t_reset;
    check(rx_data == 8'h00, "R1 data", rx_data, 0);
    check(!err_parity && !err_frame && !err_overrun, "R1 flags",
          {err_parity, err_frame, err_overrun}, 0);
    check(!rx_done && !rx_err, "R1 events", {rx_done, rx_err}, 0);
  endtask

  task automatic t_eight_bit;
    int d0 = n_done, e0 = n_err;
    par_sel = 2'b00; len8 = 1'b1;
    send_frame(8'hA5, 8, 0, 0, 1);
    expect_char("R2 A5", 8'hA5, 1, 0, d0, e0, 0, 0, 0);
    d0 = n_done; e0 = n_err;
    send_frame(8'h3C, 8, 0, 0, 1);
    expect_char("R2 3C", 8'h3C, 1, 0, d0, e0, 0, 0, 0);
  endtask

  task automatic t_seven_bit;
    int d0 = n_done, e0 = n_err;
    len8 = 1'b0;
    send_frame(8'h5A, 7, 0, 0, 1);
    expect_char("R3 7bit", 8'h5A, 1, 0, d0, e0, 0, 0, 0);
    len8 = 1'b1;
  endtask

  task automatic t_parity_checks;
    int d0 = n_done, e0 = n_err;
    par_sel = 2'b10; err_route = 1'b0;
    send_frame(8'h03, 8, 1, 1, 1);
    expect_char("R4 odd good", 8'h03, 1, 0, d0, e0, 0, 0, 0);
    d0 = n_done; e0 = n_err;
    send_frame(8'h03, 8, 1, 0, 1);
    expect_char("R4 odd bad R9 route0", 8'h03, 0, 1, d0, e0, 1, 0, 0);
    par_sel = 2'b11;
    d0 = n_done; e0 = n_err;
    send_frame(8'h07, 8, 1, 1, 1);
    expect_char("R4 even good", 8'h07, 1, 0, d0, e0, 0, 0, 0);
    err_route = 1'b1;
    d0 = n_done; e0 = n_err;
    send_frame(8'h07, 8, 1, 0, 1);
    expect_char("R4 even bad R9 route1", 8'h07, 1, 0, d0, e0, 1, 0, 0);
    err_route = 1'b0;
  endtask

  task automatic t_zero_parity;
    int d0 = n_done, e0 = n_err;
    par_sel = 2'b01;
    send_frame(8'h81, 8, 1, 0, 1);
    expect_char("R5 slot 0", 8'h81, 1, 0, d0, e0, 0, 0, 0);
    d0 = n_done; e0 = n_err;
    send_frame(8'h80, 8, 1, 1, 1);
    expect_char("R5 slot 1", 8'h80, 1, 0, d0, e0, 0, 0, 0);
    par_sel = 2'b00;
  endtask

  task automatic t_back_to_back;
    int d0 = n_done, e0 = n_err;
    hold_bit(1'b0);
    for (int i = 0; i < 8; i++) hold_bit(i[0]);
    hold_bit(1'b1);
    send_frame(8'hC3, 8, 0, 0, 1);
    expect_char("R6 back to back", 8'hC3, 2, 0, d0, e0, 0, 0, 0);
  endtask

  task automatic t_framing;
    int d0 = n_done, e0 = n_err;
    hold_bit(1'b0);
    for (int i = 0; i < 8; i++) hold_bit(1'b1);
    hold_bit(1'b0);
    repeat (3 * BIT_CLKS) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * BIT_CLKS) @(negedge clk);
    expect_char("R7 framing", 8'hFF, 0, 1, d0, e0, 0, 1, 0);
  endtask

  task automatic t_overrun;
    int d0 = n_done, e0 = n_err;
    auto_ack = 1'b0;
    send_frame(8'h11, 8, 0, 0, 1);
    expect_char("R8 first unread", 8'h11, 1, 0, d0, e0, 0, 0, 0);
    d0 = n_done; e0 = n_err;
    send_frame(8'h22, 8, 0, 0, 1);
    expect_char("R8 overrun", 8'h22, 0, 1, d0, e0, 0, 0, 1);
    rd_ack = 1'b1;
    @(negedge clk);
    rd_ack = 1'b0;
    auto_ack = 1'b1;
    d0 = n_done; e0 = n_err;
    send_frame(8'h33, 8, 0, 0, 1);
    expect_char("R8 after ack", 8'h33, 1, 0, d0, e0, 0, 0, 0);
  endtask

  task automatic t_glitch;
    int d0 = n_done, e0 = n_err;
    rxd = 1'b0;
    repeat (16) @(negedge clk);
    rxd = 1'b1;
    repeat (12 * BIT_CLKS) @(negedge clk);
    check(n_done == d0 && n_err == e0, "R10 glitch rejected", n_done + n_err - d0 - e0, 0);
    send_frame(8'h6E, 8, 0, 0, 1);
    expect_char("R10 after glitch", 8'h6E, 1, 0, d0, e0, 0, 0, 0);
  endtask

  task automatic t_low_at_enable;
    int d0 = n_done, e0 = n_err;
    rx_en = 1'b0;
    repeat (10) @(negedge clk);
    rxd = 1'b0;
    repeat (8) @(negedge clk);
    rx_en = 1'b1;
    repeat (BIT_CLKS - 8) @(negedge clk);
    for (int i = 0; i < 8; i++) hold_bit(i[1]);
    hold_bit(1'b1);
    repeat (8) @(negedge clk);
    expect_char("R11 low at enable", 8'hCC, 1, 0, d0, e0, 0, 0, 0);
  endtask

  task automatic t_short_drop;
    int d0 = n_done, e0 = n_err;
    fork
      send_frame(8'h96, 8, 0, 0, 1);
      begin
        repeat (3 * BIT_CLKS + 10) @(negedge clk);
        rx_en = 1'b0;
        @(negedge clk);
        rx_en = 1'b1;
      end
    join
    expect_char("R12 short drop", 8'h96, 1, 0, d0, e0, 0, 0, 0);
  endtask

  task automatic t_long_drop;
    int d0 = n_done, e0 = n_err;
    fork
      send_frame(8'hF0, 8, 0, 0, 1);
      begin
        repeat (3 * BIT_CLKS + 10) @(negedge clk);
        rx_en = 1'b0;
      end
    join
    repeat (100) @(negedge clk);
    rx_en = 1'b1;
    repeat (12 * BIT_CLKS) @(negedge clk);
    check(n_done == d0 && n_err == e0, "R12 long drop discards", n_done + n_err - d0 - e0, 0);
    send_frame(8'h4B, 8, 0, 0, 1);
    expect_char("R12 after long drop", 8'h4B, 1, 0, d0, e0, 0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    pwr_en = 1'b1;
    rx_en = 1'b1;
    repeat (BIT_CLKS) @(negedge clk);
    t_eight_bit();
    t_seven_bit();
    t_parity_checks();
    t_zero_parity();
    t_back_to_back();
    t_framing();
    t_overrun();
    t_glitch();
    t_low_at_enable();
    t_short_drop();
    t_long_drop();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule